// File: doc/BRIEF.md
# SD Host Interrupt Status and Mask Unit

This unit keeps the interrupt side of an SD/MMC host controller. Single-cycle event pulses from the command, data and card-detect logic set sticky flags in a 32-bit status word. A 23-bit error-detail word records the fine-grained error causes, and groups of its bits are ORed into five summary error flags of the status word. Three live levels (card present, write protect, command busy) show up in the status word as read-only bits that never raise an interrupt.

Software clears a flag by writing 0 to its status bit; a 1 leaves the bit alone. A 32-bit mask word disables a source when its bit is 1. The single interrupt line is high whenever a pending flag has its mask bit at 0. A control bit acts as a soft reset: while it is 0 every flag and every detail bit is held clear. Access goes through a small synchronous write/read port with four word addresses.

Top module: `sd_irq_status_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, status flags and detail bits are 0, the mask reads 0x8B7F031D (every maskable source disabled), the control word reads 1 and `irq_o` is low.
- R2: `evt_i` bit k sets status bit P[k] at the next clock edge, with P = {0, 2, 3, 4, 20, 21, 24, 25, 27, 31} for k = 0..9 (response end, data end, card removed, card inserted, RX overflow, TX underrun, RX ready, TX request, bit 27 event, illegal access); the flag stays set until acknowledged or reset.
- R3: A write to address 0 clears every flag whose written bit is 0 and leaves every flag whose written bit is 1 unchanged.
- R4: When an event and a clearing write hit the same flag in the same cycle, the flag is set afterwards.
- R5: A write to address 1 stores the written word ANDed with 0x8B7F031D; bits outside that set always read 0.
- R6: `irq_o` is a register that, after each clock edge, equals the OR over all bits of (flag AND NOT mask), computed from the flags and mask as updated at that edge.
- R7: Status bits 5, 7 and 30 read the live levels `card_present_i`, `wr_protect_i` and `cmd_busy_i`; writes to address 0 do not change them and they never drive `irq_o`.
- R8: `det_set_i` bit j sets detail bit j at the next edge; the detail word reads at address 2 in bits 22:0 (bits 31:23 read 0), and writes to address 2 have no effect.
- R9: Status bit 16 is the OR of detail bits 1:0, bit 17 of 11:8, bit 18 of 5:2, bit 19 of 22:20, and bit 22 of 17:16.
- R10: Writing 0 to one of those summary bits clears its detail group only; a detail bit set in the same cycle stays set; detail bits 6, 7, 12 to 15, 18 and 19 are cleared only by reset or soft reset.
- R11: Control bit 0 at address 3 resets to 1; while it reads 0, every flag and detail bit is cleared at each edge and events are dropped, the mask keeps its value, and writing 1 resumes normal operation.
- R12: `reg_rdata_o` is registered: after an edge it holds the word at `reg_addr_i` as it stood before that edge (0 status, 1 mask, 2 detail, 3 control with bits 31:1 at 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 10 | Event pulses for the directly set flags |
| det_set_i | input | 23 | Set pulses for the error-detail bits |
| card_present_i | input | 1 | Live card-present level |
| wr_protect_i | input | 1 | Live write-protect level |
| cmd_busy_i | input | 1 | Live command-busy level |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request, registered |

## Verification
The delicate overlap is a hardware event landing on a flag in the very cycle software writes 0 to clear it, together with its detail-side twin, a detail bit being set while its summary flag is acknowledged. Both are provoked by directed cycles that drive the pulse and the clearing write on the same edge, and by a random phase that overlaps sparse events, detail pulses and status writes freely. The bench judges each case by reading the status and detail words back on the following cycle and by checking `irq_o` after every edge against a cycle model built from the requirements.

// File: rtl/sdirq_pkg.sv
package sdirq_pkg;
  localparam int REG_W  = 32;
  localparam int DET_W  = 23;
  localparam int ADDR_W = 2;
  localparam int N_DIR  = 10;
  localparam int N_SUM  = 5;

  localparam logic [REG_W-1:0] MASKABLE = 32'h8B7F031D;

  // status bit positions fed straight from event pulses
  localparam int DIR_POS [N_DIR] = '{0, 2, 3, 4, 20, 21, 24, 25, 27, 31};
  // summary error bits and the detail groups folded into each
  localparam int SUM_POS [N_SUM] = '{16, 17, 18, 19, 22};
  localparam logic [DET_W-1:0] SUM_GRP [N_SUM] =
    '{23'h000003, 23'h000F00, 23'h00003C, 23'h700000, 23'h030000};

  localparam int LIVE_PRESENT = 5;
  localparam int LIVE_WPROT   = 7;
  localparam int LIVE_BUSY    = 30;

  typedef enum logic [ADDR_W-1:0] {
    SEL_STATUS = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_DETAIL = 2'd2,
    SEL_CTRL   = 2'd3
  } reg_sel_e;

  function automatic logic [DET_W-1:0] grouped_bits();
    logic [DET_W-1:0] r;
    r = '0;
    for (int k = 0; k < N_SUM; k++) r = r | SUM_GRP[k];
    return r;
  endfunction

  localparam logic [DET_W-1:0] UNGROUPED = ~grouped_bits();
endpackage

// File: rtl/sdirq_flags.sv
module sdirq_flags
  import sdirq_pkg::*;
#(
  parameter int N = N_DIR
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_all,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] ack_clr_i,
  output logic [N-1:0] flag_q,
  output logic [N-1:0] flag_n
);
  // set has priority over acknowledge; soft reset over both
  always_comb begin
    if (clr_all) flag_n = '0;
    else         flag_n = evt_i | (flag_q & ~ack_clr_i);
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= flag_n;
  end

  AST_EVT_STICKS: assert property (@(posedge clk) disable iff (rst)
    !clr_all |=> ((flag_q & $past(evt_i)) == $past(evt_i)));             // R2
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !clr_all |=> ((flag_q & $past(ack_clr_i & ~evt_i)) == '0));          // R3
  AST_EVT_WINS: assert property (@(posedge clk) disable iff (rst)
    (!clr_all && ((evt_i & ack_clr_i) != '0))
      |=> ((flag_q & $past(evt_i & ack_clr_i)) == $past(evt_i & ack_clr_i))); // R4
  AST_SRST_FLAGS: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (flag_q == '0));                                          // R11
endmodule

// File: rtl/sdirq_detail.sv
module sdirq_detail
  import sdirq_pkg::*;
#(
  parameter int DW = DET_W,
  parameter int NS = N_SUM
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_all,
  input  logic [DW-1:0] det_set_i,
  input  logic [NS-1:0] ack_sum_i,
  output logic [DW-1:0] det_q,
  output logic [NS-1:0] sum_q,
  output logic [NS-1:0] sum_n
);
  logic [DW-1:0] clr_mask;
  logic [DW-1:0] det_n;

  always_comb begin
    clr_mask = '0;
    for (int k = 0; k < NS; k++)
      if (ack_sum_i[k]) clr_mask = clr_mask | SUM_GRP[k];
  end

  always_comb begin
    if (clr_all) det_n = '0;
    else         det_n = det_set_i | (det_q & ~clr_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) det_q <= '0;
    else     det_q <= det_n;
  end

  for (genvar k = 0; k < NS; k++) begin : g_fold
    assign sum_q[k] = |(det_q & SUM_GRP[k]);
    assign sum_n[k] = |(det_n & SUM_GRP[k]);
  end

  AST_DET_SET: assert property (@(posedge clk) disable iff (rst)
    !clr_all |=> ((det_q & $past(det_set_i)) == $past(det_set_i)));      // R8
  AST_DET_UNGROUPED_HOLD: assert property (@(posedge clk) disable iff (rst)
    !clr_all |=> ((det_q & UNGROUPED & $past(det_q)) == ($past(det_q) & UNGROUPED))); // R10
  AST_SRST_DETAIL: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (det_q == '0));                                           // R11
endmodule

// File: rtl/sdirq_irq.sv
module sdirq_irq
  import sdirq_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] flags_n,
  input  logic [W-1:0] mask_n,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(flags_n & ~mask_n & MASKABLE);
  end

  assign irq_o = irq_q;

  AST_IRQ_ALL_MASKED: assert property (@(posedge clk) disable iff (rst)
    (mask_n == MASKABLE) |=> !irq_o);                                     // R6
  AST_IRQ_NO_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (flags_n == '0) |=> !irq_o);                                          // R6
endmodule

// File: rtl/sd_irq_status_ctrl.sv
module sd_irq_status_ctrl
  import sdirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [N_DIR-1:0]  evt_i,
  input  logic [DET_W-1:0]  det_set_i,
  input  logic              card_present_i,
  input  logic              wr_protect_i,
  input  logic              cmd_busy_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_o
);
  reg_sel_e sel;
  logic     wr_status, wr_mask, wr_ctrl;
  logic     ctrl_q;
  logic     clr_all;

  assign sel       = reg_sel_e'(reg_addr_i);
  assign wr_status = reg_wr_i && (sel == SEL_STATUS);
  assign wr_mask   = reg_wr_i && (sel == SEL_MASK);
  assign wr_ctrl   = reg_wr_i && (sel == SEL_CTRL);
  assign clr_all   = !ctrl_q;

  // soft reset control bit, released after hard reset
  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= 1'b1;
    else if (wr_ctrl) ctrl_q <= reg_wdata_i[0];
  end

  // acknowledge vectors picked out of the written status word
  logic [N_DIR-1:0] ack_clr;
  logic [N_SUM-1:0] ack_sum;

  for (genvar g = 0; g < N_DIR; g++) begin : g_ack_dir
    assign ack_clr[g] = wr_status & ~reg_wdata_i[DIR_POS[g]];
  end
  for (genvar k = 0; k < N_SUM; k++) begin : g_ack_sum
    assign ack_sum[k] = wr_status & ~reg_wdata_i[SUM_POS[k]];
  end

  logic [N_DIR-1:0] flag_q, flag_n;
  logic [DET_W-1:0] det_q;
  logic [N_SUM-1:0] sum_q, sum_n;

  sdirq_flags #(.N(N_DIR)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .clr_all   (clr_all),
    .evt_i     (evt_i),
    .ack_clr_i (ack_clr),
    .flag_q    (flag_q),
    .flag_n    (flag_n)
  );

  sdirq_detail #(.DW(DET_W), .NS(N_SUM)) u_detail (
    .clk       (clk),
    .rst       (rst),
    .clr_all   (clr_all),
    .det_set_i (det_set_i),
    .ack_sum_i (ack_sum),
    .det_q     (det_q),
    .sum_q     (sum_q),
    .sum_n     (sum_n)
  );

  // scatter compact flag vectors into status bit positions
  logic [REG_W-1:0] flags_vec_q, flags_vec_n, live_vec;

  always_comb begin
    flags_vec_q = '0;
    flags_vec_n = '0;
    for (int g = 0; g < N_DIR; g++) begin
      flags_vec_q[DIR_POS[g]] = flag_q[g];
      flags_vec_n[DIR_POS[g]] = flag_n[g];
    end
    for (int k = 0; k < N_SUM; k++) begin
      flags_vec_q[SUM_POS[k]] = sum_q[k];
      flags_vec_n[SUM_POS[k]] = sum_n[k];
    end
  end

  always_comb begin
    live_vec = '0;
    live_vec[LIVE_PRESENT] = card_present_i;
    live_vec[LIVE_WPROT]   = wr_protect_i;
    live_vec[LIVE_BUSY]    = cmd_busy_i;
  end

  // mask word; non-maskable positions are forced to 0
  logic [REG_W-1:0] mask_q, mask_n;

  assign mask_n = wr_mask ? (reg_wdata_i & MASKABLE) : mask_q;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= MASKABLE;
    else     mask_q <= mask_n;
  end

  sdirq_irq #(.W(REG_W)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .flags_n (flags_vec_n),
    .mask_n  (mask_n),
    .irq_o   (irq_o)
  );

  // registered read port
  logic [REG_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else begin
      unique case (sel)
        SEL_STATUS: rdata_q <= flags_vec_q | live_vec;
        SEL_MASK:   rdata_q <= mask_q;
        SEL_DETAIL: rdata_q <= {{(REG_W-DET_W){1'b0}}, det_q};
        SEL_CTRL:   rdata_q <= {{(REG_W-1){1'b0}}, ctrl_q};
        default:    rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata_o = rdata_q;

  AST_MASK_STORE: assert property (@(posedge clk) disable iff (rst)
    wr_mask |=> (mask_q == ($past(reg_wdata_i) & MASKABLE)));             // R5
  AST_MASK_HOLD_SRST: assert property (@(posedge clk) disable iff (rst)
    (!wr_mask && clr_all) |=> $stable(mask_q));                           // R11
  AST_CTRL_READ: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_CTRL) |=> (reg_rdata_o[REG_W-1:1] == '0));                // R12
endmodule

// File: tb/tb_sd_irq_status_ctrl.sv
`timescale 1ns/1ps
module tb_sd_irq_status_ctrl;
  localparam int P [10] = '{0, 2, 3, 4, 20, 21, 24, 25, 27, 31};
  localparam logic [31:0] MSKABLE = 32'h8B7F031D;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  evt = '0;
  logic [22:0] det = '0;
  logic        lp = 1'b0, lw = 1'b0, lb = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  always #2.5 clk = ~clk;

  sd_irq_status_ctrl dut (
    .clk(clk), .rst(rst), .evt_i(evt), .det_set_i(det),
    .card_present_i(lp), .wr_protect_i(lw), .cmd_busy_i(lb),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  int n_cmp = 0;
  int n_err = 0;

  logic [31:0] m_dir, m_mask;
  logic [22:0] m_det;
  logic        m_ctrl;

  function automatic logic [31:0] scat(input logic [9:0] e);
    logic [31:0] r = '0;
    for (int i = 0; i < 10; i++) r[P[i]] = e[i];
    return r;
  endfunction

  function automatic logic [31:0] fold(input logic [22:0] d);
    logic [31:0] r = '0;
    r[16] = |d[1:0];
    r[17] = |d[11:8];
    r[18] = |d[5:2];
    r[19] = |d[22:20];
    r[22] = |d[17:16];
    return r;
  endfunction

  function automatic logic [31:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0:    return m_dir | fold(m_det) | (32'(lp) << 5) | (32'(lw) << 7) | (32'(lb) << 30);
      2'd1:    return m_mask;
      2'd2:    return {9'b0, m_det};
      default: return {31'b0, m_ctrl};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock cycle with model update; irq checked every cycle, read data on request
  task automatic cyc(input logic [9:0] e, input logic [22:0] d, input logic w,
                     input logic [1:0] a, input logic [31:0] wd, input string rtag);
    logic [31:0] rexp, ackm, nd, nmask;
    logic [22:0] cg, ndet;
    logic        nctrl, iexp;
    @(negedge clk);
    evt = e; det = d; wr = w; addr = a; wdata = wd;
    rexp  = exp_read(a);
    ackm  = (w && a == 2'd0) ? wd : 32'hFFFFFFFF;
    cg    = '0;
    if (!ackm[16]) cg |= 23'h000003;
    if (!ackm[17]) cg |= 23'h000F00;
    if (!ackm[18]) cg |= 23'h00003C;
    if (!ackm[19]) cg |= 23'h700000;
    if (!ackm[22]) cg |= 23'h030000;
    nd    = !m_ctrl ? 32'h0 : (scat(e) | (m_dir & ackm));
    ndet  = !m_ctrl ? 23'h0 : (d | (m_det & ~cg));
    nmask = (w && a == 2'd1) ? (wd & MSKABLE) : m_mask;
    nctrl = (w && a == 2'd3) ? wd[0] : m_ctrl;
    iexp  = |((nd | fold(ndet)) & ~nmask & MSKABLE);
    @(posedge clk);
    m_dir = nd; m_det = ndet; m_mask = nmask; m_ctrl = nctrl;
    #1;
    chk("R6 irq", {31'b0, irq}, {31'b0, iexp});
    if (rtag != "") chk(rtag, rdata, rexp);
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    cyc('0, '0, 1'b0, a, '0, tag);
  endtask

  task automatic wreg(input logic [1:0] a, input logic [31:0] wd);
    cyc('0, '0, 1'b1, a, wd, "");
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5D1A0C3));
    m_dir = '0; m_det = '0; m_mask = MSKABLE; m_ctrl = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 / R12: reset values through the read port
    #1 chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    rd(2'd0, "R1 status");
    rd(2'd1, "R1 mask");
    rd(2'd2, "R1 detail");
    rd(2'd3, "R12 control");

    // R2 / R3 / R6: each event alone, unmasked, then cleared by a single 0
    wreg(2'd1, 32'h0);
    for (int i = 0; i < 10; i++) begin
      cyc(10'(1 << i), '0, 1'b0, 2'd0, '0, "");
      rd(2'd0, "R2 event sets flag");
      wreg(2'd0, ~(32'h1 << P[i]));
      rd(2'd0, "R3 write zero clears");
    end

    // R3: writing all ones leaves pending flags alone
    cyc(10'h3FF, '0, 1'b0, 2'd0, '0, "");
    wreg(2'd0, 32'hFFFFFFFF);
    rd(2'd0, "R3 ones keep flags");

    // R4: event and clearing write together on bit 0
    wreg(2'd0, 32'h0);
    cyc(10'h001, '0, 1'b1, 2'd0, 32'h0, "");
    rd(2'd0, "R4 event wins over ack");

    // R5 / R6: mask readback and masked interrupt
    wreg(2'd1, 32'hFFFFFFFF);
    rd(2'd1, "R5 mask keeps maskable bits only");
    wreg(2'd1, 32'hFFFFFFFE);
    rd(2'd1, "R5 partial mask");
    wreg(2'd1, 32'h0);

    // R7: live levels visible, not cleared, no interrupt
    wreg(2'd0, 32'h0);
    lp = 1'b1; lw = 1'b1; lb = 1'b1;
    rd(2'd0, "R7 live bits");
    wreg(2'd0, 32'h0);
    rd(2'd0, "R7 live bits after ack");
    lp = 1'b0; lb = 1'b0;

    // R8 / R9 / R10: detail set, fold, write ignored, group clear
    cyc('0, 23'h7FFFFF, 1'b0, 2'd0, '0, "");
    rd(2'd2, "R8 detail set");
    rd(2'd0, "R9 summary fold");
    wreg(2'd2, 32'h0);
    rd(2'd2, "R8 detail write ignored");
    wreg(2'd0, ~(32'h1 << 17));
    rd(2'd2, "R10 ack bit17 clears 11:8 only");
    wreg(2'd0, 32'h0);
    rd(2'd2, "R10 ungrouped bits survive ack");
    cyc('0, 23'h000100, 1'b1, 2'd0, 32'h0, "");
    rd(2'd2, "R10 detail set wins over ack");
    cyc('0, 23'h100000, 1'b0, 2'd0, '0, "");
    rd(2'd0, "R9 bit19 from detail 20");

    // R11: soft reset clears and drops events, mask kept
    cyc(10'h3FF, '0, 1'b1, 2'd1, 32'h00000300, "");
    wreg(2'd3, 32'h0);
    cyc(10'h3FF, 23'h7FFFFF, 1'b0, 2'd0, '0, "");
    rd(2'd0, "R11 status held clear");
    rd(2'd2, "R11 detail held clear");
    rd(2'd1, "R11 mask kept");
    rd(2'd3, "R11 control reads 0");
    wreg(2'd3, 32'h1);
    cyc(10'h001, '0, 1'b0, 2'd0, '0, "");
    rd(2'd0, "R11 events resume");

    // random phase over all functions
    for (int n = 0; n < 600; n++) begin
      logic [9:0]  e;
      logic [22:0] d;
      logic        w;
      logic [1:0]  a;
      logic [31:0] wd;
      e  = 10'($urandom & $urandom & $urandom);
      d  = 23'($urandom & $urandom & $urandom);
      w  = ($urandom % 10) < 3;
      a  = 2'($urandom);
      wd = $urandom | $urandom;
      if (a == 2'd3) wd[0] = ($urandom % 10) != 0;
      lp = 1'($urandom); lw = 1'($urandom); lb = 1'($urandom);
      cyc(e, d, w, a, wd, w ? "" : "R12 random readback");
    end

    summary();
    $finish;
  end
endmodule